// File: doc/BRIEF.md
# Threaded Two-Bank Register File

This block is the general-purpose register store of a multithreaded processing engine. It holds two banks, A and B, each of 128 words of 32 bits. Every access carries a bank, a register number and an addressing-mode bit.

- In relative mode, the number is resolved inside a private window that belongs to the thread named on the thread-ID input.
- In absolute mode, the number selects the register in the bank directly. This lets threads exchange values through shared registers.

A static configuration input selects between two thread counts:

- With eight threads, each thread owns 16 registers per bank.
- With four threads, each thread owns 32 registers per bank.

Each cycle the block accepts two reads and one write. Read data appear one cycle after the request. A write bypasses to a read of the same physical register in the same cycle. The block flags a read conflict when both reads target one bank. It flags a thread error when the thread ID lies outside the configured thread count.

Top module: `mt_regfile`

## Requirements
- R1: After reset every register of both banks reads as zero, and all outputs are zero while reset is held.
- R2: With the eight-thread setting (`cfg_eight_thr`=1), a relative access maps to physical register thread_id*16 + (number mod 16).
- R3: With the four-thread setting (`cfg_eight_thr`=0), a relative access maps to physical register thread_id*32 + (number mod 32).
- R4: An absolute access (`*_abs`=1) maps to physical register equal to the 7-bit number, so a value written by one thread is readable by any other thread.
- R5: Read data are presented one cycle after the request. A read port that was not enabled presents zero.
- R6: The bank bit selects bank A when 0 and bank B when 1. A write to one bank leaves the same index of the other bank unchanged.
- R7: When both read ports are enabled on the same bank, `rd_conflict` is 1 one cycle later. Port 0 is served and port 1 presents zero.
- R8: A read of the physical register being written in the same cycle returns the new write data.
- R9: With the four-thread setting, a thread ID of 4 to 7 on a cycle that has any request raises `tid_err` one cycle later. That cycle's write is suppressed and its reads present zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_eight_thr | input | 1 | 1 selects eight threads, 0 selects four threads |
| thread_id | input | 3 | Thread issuing this cycle's requests |
| wr_en | input | 1 | Write request |
| wr_bank | input | 1 | Write bank (0=A, 1=B) |
| wr_abs | input | 1 | Write addressing mode (1=absolute) |
| wr_num | input | 7 | Write register number |
| wr_data | input | 32 | Write data |
| rd0_en | input | 1 | Read port 0 request |
| rd0_bank | input | 1 | Read port 0 bank |
| rd0_abs | input | 1 | Read port 0 addressing mode |
| rd0_num | input | 7 | Read port 0 register number |
| rd1_en | input | 1 | Read port 1 request |
| rd1_bank | input | 1 | Read port 1 bank |
| rd1_abs | input | 1 | Read port 1 addressing mode |
| rd1_num | input | 7 | Read port 1 register number |
| rd0_data | output | 32 | Read port 0 data, one cycle after request |
| rd1_data | output | 32 | Read port 1 data, one cycle after request |
| rd_conflict | output | 1 | Both reads targeted one bank in the previous cycle |
| tid_err | output | 1 | Invalid thread ID with a request in the previous cycle |

## Verification
Every result of this block is due exactly one clock after its request. This covers both read data words, the conflict flag and the thread-error flag. A write becomes visible to reads in the same cycle through the bypass, and to all later reads afterwards. The bench applies a request just after a falling edge and lets the rising edge register it. At the next falling edge it compares all four outputs against a behavioural model that has already applied that request. No result is therefore sampled in the cycle of its own request or later than its due cycle.

// File: rtl/mt_regfile_pkg.sv
package mt_regfile_pkg;
    localparam int DATA_W   = 32;
    localparam int BANK_REGS = 128;
    localparam int MAX_THR  = 8;
    localparam int ADDR_W   = $clog2(BANK_REGS);
    localparam int TID_W    = $clog2(MAX_THR);

    typedef struct packed {
        logic       v0;
        logic       v1;
        logic       b0;
        logic       b1;
        logic       conf;
        logic       err;
    } rf_state_t;
endpackage

// File: rtl/rf_xlate.sv
module rf_xlate #(
    parameter int ADDR_W  = 7,
    parameter int TID_W   = 3,
    parameter int MAX_THR = 8
) (
    input  logic              eight_thr,
    input  logic              abs_mode,
    input  logic [TID_W-1:0]  tid,
    input  logic [ADDR_W-1:0] num,
    output logic [ADDR_W-1:0] phys
);
    localparam int WIN8_LG = ADDR_W - TID_W;
    localparam int WIN4_LG = WIN8_LG + 1;

    always_comb begin
        if (abs_mode) begin
            phys = num;
        end else if (eight_thr) begin
            phys = (ADDR_W'(tid) << WIN8_LG) | ADDR_W'(num[WIN8_LG-1:0]);
        end else begin
            phys = (ADDR_W'(tid[TID_W-2:0]) << WIN4_LG) | ADDR_W'(num[WIN4_LG-1:0]);
        end
    end
endmodule

// File: rtl/rf_bank.sv
module rf_bank #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 128,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] rd_d, rd_q;

    always_comb begin
        rd_d = rd_q;
        if (re) begin
            if (we && (waddr == raddr)) rd_d = wdata;
            else                        rd_d = mem_q[raddr];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            rd_q <= rd_d;
            if (we) mem_q[waddr] <= wdata;
        end
    end

    assign rdata = rd_q;

    // R8: same-cycle write reaches the read
    p_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (we && re && waddr == raddr) |=> (rdata == $past(wdata)));
endmodule

// File: rtl/mt_regfile.sv
module mt_regfile
    import mt_regfile_pkg::*;
#(
    parameter int DW   = DATA_W,
    parameter int AW   = ADDR_W,
    parameter int TW   = TID_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_eight_thr,
    input  logic [TW-1:0] thread_id,
    input  logic          wr_en,
    input  logic          wr_bank,
    input  logic          wr_abs,
    input  logic [AW-1:0] wr_num,
    input  logic [DW-1:0] wr_data,
    input  logic          rd0_en,
    input  logic          rd0_bank,
    input  logic          rd0_abs,
    input  logic [AW-1:0] rd0_num,
    input  logic          rd1_en,
    input  logic          rd1_bank,
    input  logic          rd1_abs,
    input  logic [AW-1:0] rd1_num,
    output logic [DW-1:0] rd0_data,
    output logic [DW-1:0] rd1_data,
    output logic          rd_conflict,
    output logic          tid_err
);
    localparam int NPORT = 3;           // 0,1 reads, 2 write
    localparam int NBANK = 2;
    localparam int THR_HALF = MAX_THR / 2;

    logic [AW-1:0] num_a  [NPORT];
    logic          abs_a  [NPORT];
    logic [AW-1:0] phys_a [NPORT];

    assign num_a[0] = rd0_num;  assign abs_a[0] = rd0_abs;
    assign num_a[1] = rd1_num;  assign abs_a[1] = rd1_abs;
    assign num_a[2] = wr_num;   assign abs_a[2] = wr_abs;

    for (genvar p = 0; p < NPORT; p++) begin : g_xl
        rf_xlate #(.ADDR_W(AW), .TID_W(TW), .MAX_THR(MAX_THR)) i_xl (
            .eight_thr (cfg_eight_thr),
            .abs_mode  (abs_a[p]),
            .tid       (thread_id),
            .num       (num_a[p]),
            .phys      (phys_a[p])
        );
    end

    logic tid_bad, any_req, conf_now;
    assign tid_bad  = !cfg_eight_thr && (32'(thread_id) >= THR_HALF);
    assign any_req  = wr_en || rd0_en || rd1_en;
    assign conf_now = rd0_en && rd1_en && (rd0_bank == rd1_bank);

    logic          bk_we [NBANK];
    logic          bk_re [NBANK];
    logic [AW-1:0] bk_ra [NBANK];
    logic [DW-1:0] bk_rd [NBANK];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        always_comb begin
            bk_we[b] = wr_en && !tid_bad && (wr_bank == 1'(b));
            bk_re[b] = 1'b0;
            bk_ra[b] = phys_a[0];
            if (rd0_en && rd0_bank == 1'(b)) begin
                bk_re[b] = 1'b1;
                bk_ra[b] = phys_a[0];
            end else if (rd1_en && rd1_bank == 1'(b)) begin
                bk_re[b] = 1'b1;
                bk_ra[b] = phys_a[1];
            end
        end

        rf_bank #(.DATA_W(DW), .DEPTH(1 << AW)) i_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (bk_we[b]),
            .waddr (phys_a[2]),
            .wdata (wr_data),
            .re    (bk_re[b]),
            .raddr (bk_ra[b]),
            .rdata (bk_rd[b])
        );
    end

    rf_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.v0   = rd0_en && !tid_bad;
        st_d.v1   = rd1_en && !tid_bad && !conf_now;
        st_d.b0   = rd0_bank;
        st_d.b1   = rd1_bank;
        st_d.conf = conf_now;
        st_d.err  = tid_bad && any_req;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd0_data    = st_q.v0 ? bk_rd[st_q.b0] : '0;
    assign rd1_data    = st_q.v1 ? bk_rd[st_q.b1] : '0;
    assign rd_conflict = st_q.conf;
    assign tid_err     = st_q.err;

    // R7: losing port is blanked on conflict
    p_conf_blank_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_conflict |-> (rd1_data == '0));
    // R9: no bank write from an invalid thread
    p_bad_tid_nowr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tid_bad |-> !(bk_we[0] || bk_we[1]));
    // R5: idle read port presents zero
    p_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd0_en |=> (rd0_data == '0));
    // R2: eight-thread setting never raises thread error
    p_eight_ok_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_eight_thr |=> !tid_err);
endmodule

// File: tb/test_mt_regfile.sv
module test_mt_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        eight = 1'b1;
    logic [2:0]  tid = '0;
    logic        we = 0, wb = 0, wa = 0;
    logic [6:0]  wn = '0;
    logic [31:0] wd = '0;
    logic        e0 = 0, b0 = 0, a0 = 0, e1 = 0, b1 = 0, a1 = 0;
    logic [6:0]  n0 = '0, n1 = '0;
    logic [31:0] d0, d1;
    logic        conf, err;

    int n_chk = 0, n_bad = 0;
    string cur = "R1";
    int mem [2][128];
    logic [31:0] x0 = '0, x1 = '0;
    logic xc = 0, xe = 0;

    always #2 clk = ~clk;   // 250 MHz

    mt_regfile i_mt_regfile (
        .clk(clk), .rst_n(rst_n), .cfg_eight_thr(eight), .thread_id(tid),
        .wr_en(we), .wr_bank(wb), .wr_abs(wa), .wr_num(wn), .wr_data(wd),
        .rd0_en(e0), .rd0_bank(b0), .rd0_abs(a0), .rd0_num(n0),
        .rd1_en(e1), .rd1_bank(b1), .rd1_abs(a1), .rd1_num(n1),
        .rd0_data(d0), .rd1_data(d1), .rd_conflict(conf), .tid_err(err)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", cur, what, act, exp);
        end
    endtask

    function automatic int phys(input logic ab, input logic [6:0] n, input logic [2:0] t);
        int w;
        if (ab) return int'(n);
        w = eight ? 16 : 32;
        return (int'(t) * w + int'(n) % w) % 128;
    endfunction

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // apply one request, then compare the results at the next falling edge
    task automatic cyc(input logic iwe, iwb, iwa, input logic [6:0] iwn, input logic [31:0] iwd,
                       input logic ie0, ib0, ia0, input logic [6:0] in0,
                       input logic ie1, ib1, ia1, input logic [6:0] in1, input logic [2:0] it);
        logic bad, cf;
        we = iwe; wb = iwb; wa = iwa; wn = iwn; wd = iwd;
        e0 = ie0; b0 = ib0; a0 = ia0; n0 = in0;
        e1 = ie1; b1 = ib1; a1 = ia1; n1 = in1; tid = it;
        bad = !eight && it >= 3'd4;
        cf  = ie0 && ie1 && ib0 == ib1;
        if (rst_n) begin
            if (iwe && !bad) mem[iwb][phys(iwa, iwn, it)] = int'(iwd);
            x0 = (ie0 && !bad) ? 32'(mem[ib0][phys(ia0, in0, it)]) : '0;
            x1 = (ie1 && !bad && !cf) ? 32'(mem[ib1][phys(ia1, in1, it)]) : '0;
            xc = cf;
            xe = bad && (iwe || ie0 || ie1);
        end else begin
            x0 = '0; x1 = '0; xc = 0; xe = 0;
        end
        @(negedge clk);
        chk("rd0_data", d0, x0);
        chk("rd1_data", d1, x1);
        chk("rd_conflict", 32'(conf), 32'(xc));
        chk("tid_err", 32'(err), 32'(xe));
    endtask

    task automatic wr(input logic bk, ab, input logic [6:0] n, input logic [31:0] d, input logic [2:0] t);
        cyc(1, bk, ab, n, d, 0, 0, 0, '0, 0, 0, 0, '0, t);
    endtask

    task automatic rd(input logic bk, ab, input logic [6:0] n, input logic [2:0] t);
        cyc(0, 0, 0, '0, '0, 1, bk, ab, n, 1, ~bk, ab, n, t);
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int b = 0; b < 2; b++) for (int i = 0; i < 128; i++) mem[b][i] = 0;
        @(negedge clk);
        // R1: outputs held at zero during reset even with requests
        cur = "R1";
        cyc(1, 0, 1, 7'd3, 32'hDEAD, 1, 0, 1, 7'd3, 1, 1, 1, 7'd3, 3'd0);
        cyc(0, 0, 0, '0, '0, 1, 0, 1, 7'd0, 0, 0, 0, '0, 3'd0);
        rst_n = 1'b1;
        rd(0, 1, 7'd0, 0); rd(0, 1, 7'd127, 0); rd(1, 1, 7'd3, 0);

        // R4: absolute fill of both banks, read back from other threads
        cur = "R4";
        for (int i = 0; i < 128; i++) begin
            wr(0, 1, 7'(i), 32'hA000_0000 + 32'(i), 3'(i));
            wr(1, 1, 7'(i), 32'hB000_0000 + 32'(i), 3'(i + 1));
        end
        for (int i = 0; i < 128; i += 5) rd(i[0], 1, 7'(i), 3'(7 - i % 8));

        // R2: eight-thread windows of 16, high number bits masked
        cur = "R2"; eight = 1;
        for (int t = 0; t < 8; t++) begin
            wr(0, 0, 7'd21, 32'h2000 + 32'(t), 3'(t));     // 21 mod 16 = 5
            rd(0, 1, 7'(t * 16 + 5), 3'(t));
            rd(0, 0, 7'd5, 3'(t));
        end

        // R3: four-thread windows of 32
        cur = "R3"; eight = 0;
        for (int t = 0; t < 4; t++) begin
            wr(1, 0, 7'd40, 32'h3000 + 32'(t), 3'(t));     // 40 mod 32 = 8
            rd(1, 1, 7'(t * 32 + 8), 3'(t));
            rd(1, 0, 7'd31, 3'(t));
        end

        // R6: bank isolation at equal index
        cur = "R6";
        wr(0, 1, 7'd77, 32'h6666_0000, 3'd0);
        cyc(0, 0, 0, '0, '0, 1, 0, 1, 7'd77, 1, 1, 1, 7'd77, 3'd1);

        // R7: two reads on one bank
        cur = "R7";
        cyc(0, 0, 0, '0, '0, 1, 1, 1, 7'd10, 1, 1, 1, 7'd11, 3'd2);
        cyc(0, 0, 0, '0, '0, 1, 0, 1, 7'd12, 1, 0, 1, 7'd13, 3'd2);

        // R8: write and read of the same register in one cycle
        cur = "R8";
        cyc(1, 1, 1, 7'd50, 32'h8888_1234, 1, 1, 1, 7'd50, 1, 0, 1, 7'd50, 3'd3);
        cyc(1, 0, 0, 7'd2, 32'h8888_5678, 1, 0, 1, 7'd66, 0, 0, 0, '0, 3'd2);

        // R9: invalid thread in four-thread mode
        cur = "R9";
        cyc(1, 0, 1, 7'd9, 32'h9999_9999, 1, 0, 1, 7'd9, 0, 0, 0, '0, 3'd5);
        rd(0, 1, 7'd9, 3'd1);
        cyc(0, 0, 0, '0, '0, 0, 0, 0, '0, 0, 0, 0, '0, 3'd6);

        // R5: mixed random traffic, including idle ports
        cur = "R5";
        for (int k = 0; k < 3000; k++) begin
            if (k % 500 == 0) eight = ~eight;
            cyc(1'($urandom), 1'($urandom), 1'($urandom), 7'($urandom), $urandom,
                1'($urandom), 1'($urandom), 1'($urandom), 7'($urandom),
                1'($urandom), 1'($urandom), 1'($urandom), 7'($urandom), 3'($urandom));
        end
        finish_run();
    end
endmodule